// File: doc/BRIEF.md
# Shared-Pin Bidirectional I/O Port

This block is an eight-pin general-purpose I/O port that software reaches over a simple banked register bus. It keeps an output data latch, a per-pin direction register and a 4-bit analog-enable mask. Each pin is presented to the pad ring as three signals: an input level, an output value and an output enable. Software reads the port register and gets the live, synchronized pin levels. It does not get the latch contents back.

The four low pins can be handed to an analog converter. While a pin's mask bit is set, the port stops driving that pin and reads it as zero. The mask comes out of reset all ones, so every analog-capable pin starts in analog mode. The four high pins are shared with fixed peripheral functions:

| Pin | Peripheral function |
|-----|---------------------|
| 4 | capture input |
| 5 | PWM output |
| 6 | serial transmit |
| 7 | serial receive |

Each peripheral function has its own enable. An enabled output function takes over its pin's value and its output enable. An enabled input function receives the synchronized pin level.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset the direction register is 8'hFF, the data latch is 8'h00 and the analog mask is 4'hF. All eight padOe bits are 0.
- R2: Register accesses are decoded only when busBank equals 5. Writes made with any other bank value leave all registers unchanged. Reads made with any other bank value return 8'h00.
- R3: A write to address 0 loads the data latch. padOut[i] equals latch bit i on every pin that no peripheral overrides.
- R4: A write to address 1 loads the direction register, and a read of address 1 returns it. On a digital pin without a peripheral override, a direction bit of 0 gives padOe=1 and a direction bit of 1 gives padOe=0.
- R5: A read of address 0 returns the pad input levels after a two-flop synchronizer. A change on padIn is visible to the read after two rising clock edges. Analog pins read as 0.
- R6: A write to address 2 loads the analog mask from bits 3:0, and a read of address 2 returns the mask with bits 7:4 as 0. Mask bit i (i = 0 to 3) set to 1 puts pin i in analog mode. In analog mode padOe[i] is 0 and the read value of the pin is 0, whatever the direction bit holds.
- R7: While pwmEn is 1, pin 5 has padOe=1 and padOut equal to pwmOut, whatever the direction and latch bits hold.
- R8: While txEn is 1, pin 6 has padOe=1 and padOut equal to txOut, whatever the direction and latch bits hold.
- R9: capIn equals the synchronized level of pin 4 while capEn is 1, and is 0 otherwise. rxIn equals the synchronized level of pin 7 while rxEn is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busBank | input | 4 | Bank select value for the access |
| busAddr | input | 2 | Register address: 0 port, 1 direction, 2 analog mask |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables, 1 = drive |
| pwmEn | input | 1 | PWM function owns pin 5 |
| pwmOut | input | 1 | PWM output value |
| txEn | input | 1 | Serial transmit owns pin 6 |
| txOut | input | 1 | Serial transmit value |
| capEn | input | 1 | Capture input enabled |
| rxEn | input | 1 | Serial receive enabled |
| capIn | output | 1 | Synchronized pin 4 to capture unit |
| rxIn | output | 1 | Synchronized pin 7 to serial receiver |

## Verification
The direction register, the data latch and the pad input are each swept through all 256 codes with the analog mask cleared. These sweeps separate the output-enable path, the output-value path and the synchronized read path bit by bit, and they would expose a swapped or inverted bit. The analog mask is swept through all 16 codes with every pin configured as an output and padIn held high. This shows that each mask bit gates exactly its own pin's enable and read value. Peripheral enables are tried against latch and direction values that oppose them, which separates override from pass-through, and out-of-bank accesses are checked for no effect on the state that can be read back.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrCfg;
    logic rdPort;
    logic rdDir;
    logic rdCfg;
  } portStrb_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int BANK_ID = 5
) (
  input  logic [BANK_W-1:0] busBank,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrb_t         strb
);
  logic bankHit;
  logic wrHit;
  logic rdHit;

  assign bankHit = (busBank == BANK_W'(BANK_ID));
  assign wrHit   = bankHit & busWrEn;
  assign rdHit   = bankHit & busRdEn;

  always_comb begin
    strb         = '0;
    strb.wrLatch = wrHit & (busAddr == ADDR_PORT);
    strb.wrDir   = wrHit & (busAddr == ADDR_DIR);
    strb.wrCfg   = wrHit & (busAddr == ADDR_CFG);
    strb.rdPort  = rdHit & (busAddr == ADDR_PORT);
    strb.rdDir   = rdHit & (busAddr == ADDR_DIR);
    strb.rdCfg   = rdHit & (busAddr == ADDR_CFG);
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ANA_PINS = 4,
  parameter int CAP_PIN  = 4,
  parameter int PWM_PIN  = 5,
  parameter int TX_PIN   = 6,
  parameter int RX_PIN   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  portStrb_t           strb,
  input  logic [WIDTH-1:0]    wrData,
  output logic [WIDTH-1:0]    rdData,
  input  logic [WIDTH-1:0]    padIn,
  output logic [WIDTH-1:0]    padOut,
  output logic [WIDTH-1:0]    padOe,
  input  logic                pwmEn,
  input  logic                pwmOut,
  input  logic                txEn,
  input  logic                txOut,
  input  logic                capEn,
  input  logic                rxEn,
  output logic                capIn,
  output logic                rxIn,
  output logic [WIDTH-1:0]    latchQ,
  output logic [WIDTH-1:0]    dirQ,
  output logic [ANA_PINS-1:0] anaMask,
  output logic [WIDTH-1:0]    syncPin
);
  localparam int PAD_W = WIDTH - ANA_PINS;

  logic [WIDTH-1:0] syncMeta;
  logic [WIDTH-1:0] pinView;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchQ  <= '0;
      dirQ    <= '1;
      anaMask <= '1;
    end else begin
      if (strb.wrLatch) latchQ  <= wrData;
      if (strb.wrDir)   dirQ    <= wrData;
      if (strb.wrCfg)   anaMask <= wrData[ANA_PINS-1:0];
    end
  end

  // two-stage input synchronizer standing in for the hysteresis buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncMeta <= '0;
      syncPin  <= '0;
    end else begin
      syncMeta <= padIn;
      syncPin  <= syncMeta;
    end
  end

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
    logic anaBit;
    logic ovrEn;
    logic ovrVal;
    if (gi < ANA_PINS) begin : g_ana
      assign anaBit = anaMask[gi];
    end else begin : g_dig
      assign anaBit = 1'b0;
    end
    if (gi == PWM_PIN) begin : g_pwm
      assign ovrEn  = pwmEn;
      assign ovrVal = pwmOut;
    end else if (gi == TX_PIN) begin : g_tx
      assign ovrEn  = txEn;
      assign ovrVal = txOut;
    end else begin : g_none
      assign ovrEn  = 1'b0;
      assign ovrVal = 1'b0;
    end
    assign padOe[gi]   = anaBit ? 1'b0 : (ovrEn | ~dirQ[gi]);
    assign padOut[gi]  = ovrEn ? ovrVal : latchQ[gi];
    assign pinView[gi] = anaBit ? 1'b0 : syncPin[gi];
  end

  assign capIn = capEn & syncPin[CAP_PIN];
  assign rxIn  = rxEn & syncPin[RX_PIN];

  always_comb begin
    rdData = '0;
    if (strb.rdPort) rdData = pinView;
    if (strb.rdDir)  rdData = dirQ;
    if (strb.rdCfg)  rdData = {{PAD_W{1'b0}}, anaMask};
  end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ANA_PINS = 4,
  parameter int BANK_W   = 4,
  parameter int BANK_ID  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] busBank,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  input  logic              pwmEn,
  input  logic              pwmOut,
  input  logic              txEn,
  input  logic              txOut,
  input  logic              capEn,
  input  logic              rxEn,
  output logic              capIn,
  output logic              rxIn
);
  portStrb_t           strb;
  logic [WIDTH-1:0]    latchQ;
  logic [WIDTH-1:0]    dirQ;
  logic [ANA_PINS-1:0] anaMask;
  logic [WIDTH-1:0]    syncPin;

  gpio_port_ctrl #(.BANK_W(BANK_W), .BANK_ID(BANK_ID)) u_ctrl (
    .busBank(busBank), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strb(strb)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(busWrData),
    .rdData(busRdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pwmEn(pwmEn), .pwmOut(pwmOut), .txEn(txEn), .txOut(txOut),
    .capEn(capEn), .rxEn(rxEn), .capIn(capIn), .rxIn(rxIn),
    .latchQ(latchQ), .dirQ(dirQ), .anaMask(anaMask), .syncPin(syncPin)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH    = 8,
  parameter int ANA_PINS = 4,
  parameter int BANK_W   = 4,
  parameter int BANK_ID  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [BANK_W-1:0]   busBank,
  input logic                busWrEn,
  input logic [WIDTH-1:0]    padOut,
  input logic [WIDTH-1:0]    padOe,
  input logic                pwmEn,
  input logic                pwmOut,
  input logic                txEn,
  input logic                txOut,
  input logic                capEn,
  input logic                rxEn,
  input logic                capIn,
  input logic                rxIn,
  input logic [WIDTH-1:0]    latchQ,
  input logic [WIDTH-1:0]    dirQ,
  input logic [ANA_PINS-1:0] anaMask,
  input logic [WIDTH-1:0]    syncPin
);
  assert_reset_dir_R1: assert property (@(posedge clk) $rose(rst_n) |-> (dirQ == '1) && (anaMask == '1) && (latchQ == '0));

  assert_foreign_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busBank != BANK_W'(BANK_ID)) |=> $stable(latchQ) && $stable(dirQ) && $stable(anaMask));

  assert_dir_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !anaMask[0] |-> (padOe[0] == !dirQ[0]));

  assert_analog_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (padOe[ANA_PINS-1:0] & anaMask) == '0);

  assert_pwm_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwmEn |-> padOe[5] && (padOut[5] == pwmOut));

  assert_tx_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txEn |-> padOe[6] && (padOut[6] == txOut));

  assert_cap_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capIn == (capEn && syncPin[4]));

  assert_rx_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rxIn == (rxEn && syncPin[7]));
endmodule

bind gpio_shared_port gpio_port_chk #(
  .WIDTH(WIDTH), .ANA_PINS(ANA_PINS), .BANK_W(BANK_W), .BANK_ID(BANK_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busBank(busBank), .busWrEn(busWrEn),
  .padOut(padOut), .padOe(padOe), .pwmEn(pwmEn), .pwmOut(pwmOut),
  .txEn(txEn), .txOut(txOut), .capEn(capEn), .rxEn(rxEn),
  .capIn(capIn), .rxIn(rxIn), .latchQ(latchQ), .dirQ(dirQ),
  .anaMask(anaMask), .syncPin(syncPin)
);

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] busBank = 4'd5;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic pwmEn = 0, pwmOut = 0, txEn = 0, txOut = 0, capEn = 0, rxEn = 0;
  logic capIn, rxIn;

  int errors = 0;
  int checks = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  gpio_shared_port u_dut (
    .clk(clk), .rst_n(rst_n), .busBank(busBank), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pwmEn(pwmEn), .pwmOut(pwmOut), .txEn(txEn), .txOut(txOut),
    .capEn(capEn), .rxEn(rxEn), .capIn(capIn), .rxIn(rxIn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] bank, input logic [1:0] addr, input logic [7:0] data);
    @(negedge clk);
    busBank = bank; busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busBank = 4'd5;
  endtask

  task automatic rdReg(input logic [3:0] bank, input logic [1:0] addr, output logic [7:0] val);
    @(negedge clk);
    busBank = bank; busAddr = addr; busRdEn = 1'b1;
    #1 val = busRdData;
    busRdEn = 1'b0; busBank = 4'd5;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, 8'h00);
    rdReg(4'd5, 2'd1, rd); check("R1 dir", rd, 8'hFF);
    rdReg(4'd5, 2'd2, rd); check("R1 mask", rd, 8'h0F);
    check("R1 latch", padOut, 8'h00);
    // R6 analog pins read 0 under reset mask
    padIn = 8'hFF; repeat (3) @(negedge clk);
    rdReg(4'd5, 2'd0, rd); check("R6 analog read", rd, 8'hF0);

    wr(4'd5, 2'd2, 8'hF0);  // mask cleared, upper bits ignored
    rdReg(4'd5, 2'd2, rd); check("R6 mask readback", rd, 8'h00);

    // R4 direction sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd5, 2'd1, 8'(v));
      check("R4 oe", padOe, ~8'(v));
      rdReg(4'd5, 2'd1, rd); check("R4 dir readback", rd, 8'(v));
    end
    // R3 latch sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'd5, 2'd0, 8'(v));
      check("R3 padOut", padOut, 8'(v));
    end
    // R5 input sweep with two-edge latency
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); padIn = 8'(v) ^ 8'hA5;
      @(negedge clk); padIn = 8'(v);
      rdReg(4'd5, 2'd0, rd); check("R5 one edge old", rd, 8'(v) ^ 8'hA5);
      rdReg(4'd5, 2'd0, rd); check("R5 synced", rd, 8'(v));
    end
    // R2 foreign bank
    wr(4'd5, 2'd0, 8'h3C); wr(4'd5, 2'd1, 8'h00);
    for (int b = 0; b < 16; b++) begin
      if (b != 5) begin
        wr(4'(b), 2'd0, 8'hC3); wr(4'(b), 2'd1, 8'hFF); wr(4'(b), 2'd2, 8'h0F);
        check("R2 latch kept", padOut, 8'h3C);
        check("R2 dir kept", padOe, 8'hFF);
        rdReg(4'(b), 2'd1, rd); check("R2 foreign read", rd, 8'h00);
      end
    end
    rdReg(4'd5, 2'd2, rd); check("R2 mask kept", rd, 8'h00);
    // R6 mask sweep, all outputs, pins high
    padIn = 8'hFF;
    for (int m = 0; m < 16; m++) begin
      wr(4'd5, 2'd2, 8'(m));
      check("R6 oe gated", padOe, {4'hF, ~4'(m)});
      repeat (2) @(negedge clk);
      rdReg(4'd5, 2'd0, rd); check("R6 read gated", rd, {4'hF, ~4'(m)});
    end
    wr(4'd5, 2'd2, 8'h00);
    // R7 / R8 overrides against opposing dir and latch
    wr(4'd5, 2'd1, 8'hFF); wr(4'd5, 2'd0, 8'h00);
    @(negedge clk); pwmEn = 1; pwmOut = 1; txEn = 1; txOut = 1; #1;
    check("R7 pwm oe", {7'd0, padOe[5]}, 8'd1);
    check("R7 pwm val", {7'd0, padOut[5]}, 8'd1);
    check("R8 tx oe", {7'd0, padOe[6]}, 8'd1);
    check("R8 tx val", {7'd0, padOut[6]}, 8'd1);
    wr(4'd5, 2'd0, 8'hFF); @(negedge clk); pwmOut = 0; txOut = 0; #1;
    check("R7 pwm low", {7'd0, padOut[5]}, 8'd0);
    check("R8 tx low", {7'd0, padOut[6]}, 8'd0);
    check("R3 others latch", padOut & 8'h9F, 8'h9F);
    @(negedge clk); pwmEn = 0; txEn = 0; #1;
    check("R7 R8 released", padOe, 8'h00);
    check("R3 released", padOut, 8'hFF);
    // R9 input routing
    padIn = 8'h90; repeat (3) @(negedge clk);
    check("R9 disabled", {6'd0, capIn, rxIn}, 8'd0);
    capEn = 1; rxEn = 1; #1;
    check("R9 enabled high", {6'd0, capIn, rxIn}, 8'd3);
    padIn = 8'h00; repeat (3) @(negedge clk);
    check("R9 enabled low", {6'd0, capIn, rxIn}, 8'd0);
    padIn = 8'h10; repeat (3) @(negedge clk);
    check("R9 cap only", {6'd0, capIn, rxIn}, 8'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule